// File: doc/BRIEF.md
# Interrupt Acknowledge and Response Sequencer

This block decides when a pending interrupt may be taken by a simple processor core and then runs the response that follows. Two kinds of request arrive: standard interrupts, which need a vector fetch followed by a forced subroutine call, and transfer-engine requests, which are handed to a control-block service path and never force a call. The core reports each instruction completion with a one-cycle end strobe, and flags in that same cycle whether the completed instruction was protected. One clock cycle is one state time.

A request is captured into a pending bit and becomes eligible (armed) at the next instruction end. It is acknowledged at a later unprotected instruction end. A request that arrives during an instruction, or in the same cycle as its end strobe, therefore waits for the following instruction as well. On acknowledge, the sequencer pulses `ack`, clears the pending state, raises `busy` and selects a path. The standard path lasts a fixed number of state times that depends on the stack location. The transfer-engine path lasts until the engine reports completion. The controller has three states: `SQ_IDLE`, `SQ_STD_CALL` and `SQ_PTS_SVC`. Its transitions are `T_TAKE_PTS` (idle to transfer service), `T_TAKE_STD` (idle to standard call), `T_CALL_DONE` (call timer expired, back to idle) and `T_SVC_DONE` (engine done, back to idle).

Top module: `irq_resp_seq`

## Requirements
- R1: Any cycle with a request input high makes that request pending from the next cycle. A pending request is armed by an `instr_end` cycle in which it is already pending. It is acknowledged only after a later `instr_end` cycle, with `ack` high in the cycle that directly follows that end strobe. A request raised in the same cycle as an `instr_end` is not armed by it.
- R2: An `instr_end` cycle with `instr_prot` high never leads to an acknowledge. An armed request is taken at the next `instr_end` that has `instr_prot` low.
- R3: A standard response holds `busy` high for exactly 11 cycles when `stack_ext` is 0 and 13 cycles when `stack_ext` is 1. `stack_ext` is sampled in the cycle of the end strobe that leads to the acknowledge.
- R4: A transfer-engine response raises `path_pts` (1 = transfer-engine path, 0 = standard path) together with `busy`. It has no timed call phase: `busy` stays high until a cycle with `pts_done` high, and drops in the next cycle.
- R5: The worst-case latency from a request cycle to the first cycle after the response is 56 state times for a standard request with an external stack (4 + 39 + 13). For a transfer-engine request, the latency from the request cycle to the acknowledge cycle is 43 state times (4 + 39).
- R6: When both kinds are armed at one allowed boundary, the transfer-engine request is taken first. The standard request stays armed and is taken at the next allowed boundary after the service ends.
- R7: The pending and armed state of a request are cleared in the same cycle that `ack` rises. A single request is never acknowledged twice.
- R8: A transfer-engine request raised while a transfer-engine service is running is held pending. It is armed and taken at boundaries after the service ends.
- R9: While `busy` is high, `ack` does not rise again, and `instr_end` neither arms nor takes requests.
- R10: After reset, `ack`, `busy` and `path_pts` are 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_req | input | 1 | Standard interrupt request |
| pts_req | input | 1 | Transfer-engine service request |
| stack_ext | input | 1 | 1 = stack in external memory (longer call) |
| instr_end | input | 1 | Last state time of an instruction |
| instr_prot | input | 1 | Completed instruction is protected (valid with `instr_end`) |
| pts_done | input | 1 | Transfer-engine service finished |
| ack | output | 1 | One-cycle acknowledge pulse |
| busy | output | 1 | Response phase in progress |
| path_pts | output | 1 | 1 = transfer-engine path, 0 = standard path |

## Verification
The assertions assume that the core model never raises `instr_end` while `busy` is high. They also assume that `instr_prot` is meaningful only together with `instr_end`, and that `pts_done` comes only during a transfer-engine service. The bench keeps to these rules by driving instructions only from an instruction task that it calls while the sequencer is idle, or to test R9. It raises `pts_done` only after it has observed an acknowledge on the transfer-engine path. Request pulses last one cycle and are placed relative to the end strobes, so the arming cycle and the taking cycle can be computed exactly.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    // Controller states
    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_STD_CALL = 2'd1,
        SQ_PTS_SVC  = 2'd2
    } seq_state_e;

    // Request kinds, index into the tracker array
    localparam int KIND_STD = 0;
    localparam int KIND_PTS = 1;
    localparam int NUM_KIND = 2;

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic arm,
    input  logic clr,
    output logic armed
);
    logic pend_q;
    logic armed_q;

    // New request wins over clear so that no request is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            pend_q  <= req | (pend_q & ~clr);
            armed_q <= ~clr & (armed_q | (arm & pend_q));
        end
    end

    assign armed = armed_q;

    // R7: clear empties both pending and armed state
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !req) |=> (!pend_q && !armed_q))
        else $error("R7 clear did not empty tracker");

    // R1: arming only happens on a boundary with the request already pending
    assert_arm_on_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(arm && pend_q))
        else $error("R1 armed without boundary");

endmodule

// File: rtl/irq_resp_timer.sv
module irq_resp_timer #(
    parameter int INT_LEN = 11,
    parameter int EXT_LEN = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic use_ext,
    output logic last
);
    localparam int MAX_LEN = (EXT_LEN > INT_LEN) ? EXT_LEN : INT_LEN;
    localparam int CW      = $clog2(MAX_LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= use_ext ? CW'(EXT_LEN - 1) : CW'(INT_LEN - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // R3: a load always starts a non-empty countdown
    assert_load_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !last)
        else $error("R3 timer loaded but already expired");

endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq #(
    parameter int INT_CALL_LEN = 11,
    parameter int EXT_CALL_LEN = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic std_req,
    input  logic pts_req,
    input  logic stack_ext,
    input  logic instr_end,
    input  logic instr_prot,
    input  logic pts_done,
    output logic ack,
    output logic busy,
    output logic path_pts
);
    import irq_seq_pkg::*;

    localparam int MAX_CALL = (EXT_CALL_LEN > INT_CALL_LEN) ? EXT_CALL_LEN : INT_CALL_LEN;
    localparam int LW       = $clog2(MAX_CALL + 1) + 1;

    seq_state_e state_q, state_d;
    logic       ack_q;

    logic [NUM_KIND-1:0] req_vec;
    logic [NUM_KIND-1:0] clr_vec;
    logic [NUM_KIND-1:0] armed_vec;

    logic arm_bnd;
    logic take_ok;
    logic take_pts;
    logic take_std;
    logic call_last;

    assign req_vec[KIND_STD] = std_req;
    assign req_vec[KIND_PTS] = pts_req;

    // Boundary decisions: arm on any end strobe while idle, take on unprotected ones
    always_comb begin
        arm_bnd  = instr_end & (state_q == SQ_IDLE);
        take_ok  = arm_bnd & ~instr_prot;
        take_pts = take_ok & armed_vec[KIND_PTS];
        take_std = take_ok & armed_vec[KIND_STD] & ~armed_vec[KIND_PTS];
        clr_vec[KIND_STD] = take_std;
        clr_vec[KIND_PTS] = take_pts;
    end

    genvar k;
    generate
        for (k = 0; k < NUM_KIND; k++) begin : g_track
            irq_pend_track u_track (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (req_vec[k]),
                .arm   (arm_bnd),
                .clr   (clr_vec[k]),
                .armed (armed_vec[k])
            );
        end
    endgenerate

    irq_resp_timer #(
        .INT_LEN (INT_CALL_LEN),
        .EXT_LEN (EXT_CALL_LEN)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_std),
        .use_ext (stack_ext),
        .last    (call_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (take_pts)      state_d = SQ_PTS_SVC;   // T_TAKE_PTS
                else if (take_std) state_d = SQ_STD_CALL;  // T_TAKE_STD
            end
            SQ_STD_CALL: begin
                if (call_last)     state_d = SQ_IDLE;      // T_CALL_DONE
            end
            SQ_PTS_SVC: begin
                if (pts_done)      state_d = SQ_IDLE;      // T_SVC_DONE
            end
            default:               state_d = SQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= take_pts | take_std;
        end
    end

    // Outputs
    always_comb begin
        ack      = ack_q;
        busy     = (state_q != SQ_IDLE);
        path_pts = (state_q == SQ_PTS_SVC);
    end

    // Checker state for the call length
    logic [LW-1:0] chk_len_q;
    logic          chk_ext_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_len_q <= '0;
            chk_ext_q <= 1'b0;
        end else if (take_std) begin
            chk_len_q <= '0;
            chk_ext_q <= stack_ext;
        end else if (state_q == SQ_STD_CALL) begin
            chk_len_q <= chk_len_q + 1'b1;
        end
    end

    assert_ack_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(instr_end))
        else $error("R1 ack without preceding boundary");

    assert_no_ack_after_prot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(instr_prot))
        else $error("R2 ack after protected instruction");

    assert_call_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(!path_pts)) |->
            (chk_len_q == (chk_ext_q ? LW'(EXT_CALL_LEN) : LW'(INT_CALL_LEN))))
        else $error("R3 call length wrong");

    assert_svc_ends_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(path_pts)) |-> $past(pts_done))
        else $error("R4 service ended without done");

    assert_pts_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !path_pts) |-> !$past(armed_vec[KIND_PTS]))
        else $error("R6 standard taken over armed transfer request");

    assert_no_reack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (busy && !$past(busy)))
        else $error("R9 ack while busy");

endmodule

// File: tb/irq_resp_seq_bench.sv
`timescale 1ns/1ps
module irq_resp_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic std_req = 1'b0, pts_req = 1'b0, stack_ext = 1'b0;
    logic instr_end = 1'b0, instr_prot = 1'b0, pts_done = 1'b0;
    logic ack, busy, path_pts;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ack_cnt = 0;
    int last_ack_cyc = -1;
    bit last_ack_pts = 1'b0;
    int last_fall_cyc = -1;
    bit prev_busy = 1'b0;

    always #2 clk = ~clk;

    irq_resp_seq u_irq_resp_seq (
        .clk(clk), .rst_n(rst_n), .std_req(std_req), .pts_req(pts_req),
        .stack_ext(stack_ext), .instr_end(instr_end), .instr_prot(instr_prot),
        .pts_done(pts_done), .ack(ack), .busy(busy), .path_pts(path_pts)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (ack) begin
            ack_cnt++;
            last_ack_cyc = cyc;
            last_ack_pts = path_pts;
        end
        if (prev_busy && !busy) last_fall_cyc = cyc;
        prev_busy = busy;
    end

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic sync();
        @(negedge clk);
        #1;
    endtask

    // One instruction of len state times; request pulses in its first cycle
    task automatic run_instr(int len, bit prot, bit sreq, bit preq);
        for (int i = 0; i < len; i++) begin
            instr_end  = (i == len - 1);
            instr_prot = prot && (i == len - 1);
            std_req    = sreq && (i == 0);
            pts_req    = preq && (i == 0);
            @(negedge clk);
        end
        instr_end = 1'b0; instr_prot = 1'b0; std_req = 1'b0; pts_req = 1'b0;
        #1;
    endtask

    task automatic wait_idle();
        while (busy) sync();
    endtask

    task automatic finish_pts();
        pts_done = 1'b1;
        sync();
        pts_done = 1'b0;
    endtask

    task automatic t_reset();
        check(ack == 1'b0, "R10", "ack after reset", ack, 0);
        check(busy == 1'b0, "R10", "busy after reset", busy, 0);
        check(path_pts == 1'b0, "R10", "path after reset", path_pts, 0);
        run_instr(3, 0, 0, 0);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == 0, "R10", "no ack with nothing pending", ack_cnt, 0);
    endtask

    task automatic t_std_latency(bit ext);
        int t0, n0, exp_len;
        stack_ext = ext;
        exp_len = ext ? 13 : 11;
        n0 = ack_cnt;
        t0 = cyc;
        run_instr(4, 0, 1, 0);
        run_instr(39, 0, 0, 0);
        check(ack_cnt == n0 + 1 && last_ack_cyc - t0 == 43, "R1", "std ack cycle", last_ack_cyc - t0, 43);
        check(busy && !path_pts, "R3", "std path busy", path_pts, 0);
        wait_idle();
        check(last_fall_cyc - last_ack_cyc == exp_len, "R3", "call length", last_fall_cyc - last_ack_cyc, exp_len);
        check(last_fall_cyc - t0 == 43 + exp_len, "R5", "std latency", last_fall_cyc - t0, 43 + exp_len);
        run_instr(3, 0, 0, 0);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0 + 1, "R7", "no second ack", ack_cnt, n0 + 1);
        stack_ext = 1'b0;
    endtask

    task automatic t_pts_latency();
        int t0, n0;
        n0 = ack_cnt;
        t0 = cyc;
        run_instr(4, 0, 0, 1);
        run_instr(39, 0, 0, 0);
        check(ack_cnt == n0 + 1 && last_ack_cyc - t0 == 43, "R5", "pts latency", last_ack_cyc - t0, 43);
        check(last_ack_pts == 1'b1, "R4", "pts path select", last_ack_pts, 1);
        run_instr(3, 0, 0, 0);
        run_instr(20, 0, 0, 0);
        check(busy == 1'b1, "R4", "busy held until done", busy, 1);
        check(ack_cnt == n0 + 1, "R9", "end strobes ignored while busy", ack_cnt, n0 + 1);
        finish_pts();
        check(busy == 1'b0 && last_fall_cyc == cyc, "R4", "busy drops after done", busy, 0);
    endtask

    task automatic t_protected();
        int n0;
        n0 = ack_cnt;
        run_instr(2, 0, 1, 0);
        run_instr(5, 1, 0, 0);
        check(ack_cnt == n0, "R2", "no ack after protected", ack_cnt, n0);
        run_instr(5, 1, 0, 0);
        check(ack_cnt == n0, "R2", "no ack after second protected", ack_cnt, n0);
        run_instr(4, 0, 0, 0);
        check(ack_cnt == n0 + 1 && last_ack_cyc == cyc, "R2", "ack after following instr", last_ack_cyc, cyc);
        wait_idle();
    endtask

    task automatic t_late();
        int n0;
        n0 = ack_cnt;
        run_instr(1, 0, 1, 0);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0, "R1", "late request not taken", ack_cnt, n0);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0 + 1 && last_ack_cyc == cyc, "R1", "late request taken one instr later", last_ack_cyc, cyc);
        wait_idle();
    endtask

    task automatic t_priority();
        int n0;
        n0 = ack_cnt;
        run_instr(2, 0, 1, 1);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0 + 1 && last_ack_pts == 1'b1, "R6", "pts taken first", last_ack_pts, 1);
        run_instr(4, 0, 0, 0);
        finish_pts();
        check(ack_cnt == n0 + 1, "R6", "std waits for boundary", ack_cnt, n0 + 1);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0 + 2 && last_ack_pts == 1'b0 && last_ack_cyc == cyc, "R6", "std taken next", last_ack_pts, 0);
        wait_idle();
    endtask

    task automatic t_pts_during_pts();
        int n0;
        n0 = ack_cnt;
        run_instr(2, 0, 0, 1);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0 + 1 && path_pts, "R8", "first pts taken", ack_cnt, n0 + 1);
        run_instr(2, 0, 0, 1);
        finish_pts();
        check(busy == 1'b0 && ack_cnt == n0 + 1, "R8", "new pts held during service", ack_cnt, n0 + 1);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0 + 1, "R8", "held pts armed only", ack_cnt, n0 + 1);
        run_instr(3, 0, 0, 0);
        check(ack_cnt == n0 + 2 && last_ack_pts && last_ack_cyc == cyc, "R8", "held pts taken", ack_cnt, n0 + 2);
        finish_pts();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sync();
        t_reset();
        t_std_latency(1'b1);
        t_std_latency(1'b0);
        t_pts_latency();
        t_protected();
        t_late();
        t_priority();
        t_pts_during_pts();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule